// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer of 9-bit words whose write port and read port run on independent clocks. Depth is a parameter (64 to 8192 words, a power of two). It reports four active-low status outputs: empty, full, almost-empty and almost-full. The almost thresholds are supplied at run time by a neighbouring offset-register block. Each flag is owned by exactly one clock: empty and almost-empty change only on read-clock edges, and full and almost-full change only on write-clock edges.

The write port has a second enable pin with two possible roles. Its level while reset is held low decides which role it takes. If the pin is high during reset, it is a plain second write enable. If it is low during reset, it becomes a load-select. While the load-select is low, both data writes and data reads are withheld and the `ofs_sel` output tells the offset-register block to take those accesses. A separate drive-indication output stands in for the tri-state control of the output pads.

Pointers are binary-counted, Gray-coded and passed through two-stage synchronisers into the opposite clock domain. Flags therefore assert exactly on the owning edge but release a few cycles late.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, that domain is cleared. After reset, `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1 and `dout`=0.
- R2: If `wr_en2_ld` is 1 while reset is held, the port runs in two-enable mode. A word is stored on a `wclk` rising edge when `wr_en1_n`=0, `wr_en2_ld`=1 and `full_n`=1. With `wr_en2_ld`=0 no word is stored.
- R3: If `wr_en2_ld` is 0 while reset is held, the port runs in load-select mode. In that mode `ofs_sel` = NOT `wr_en2_ld`, and while `wr_en2_ld`=0 no data word is written or read. In two-enable mode `ofs_sel` stays 0.
- R4: A word is read on an `rclk` rising edge only when `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1. The read word appears on `dout` right after that edge. With either read enable high, nothing is read.
- R5: `full_n` goes low on the write edge that stores word number DEPTH. While `full_n` is low, writes are refused and the stored contents do not change.
- R6: While `empty_n` is low, reads are refused and `dout` keeps the last word validly read. `empty_n` goes low on the read edge that removes the last word.
- R7: `almost_empty_n` is low when the unread count is `ae_level` or less, and high when it is `ae_level`+1 or more. A change of `ae_level` takes effect within a few read cycles.
- R8: `almost_full_n` goes low on the write edge after which the count is at least DEPTH − `af_level`. It is high once more than `af_level` locations are free.
- R9: Words leave in the order written, with no loss or duplication, while writes and reads run at the same time on the two clocks. The first word reaches `dout` on the read edge that follows the rise of `empty_n`.
- R10: Release of full or almost-full waits for the read pointer to cross into the write domain, and release of empty waits for the write pointer to cross into the read domain. Each crossing takes a few destination-clock cycles.
- R11: `dout_drive` = NOT `out_en_n`.
- R12: Whenever `full_n` is low, `almost_full_n` is low. Whenever `empty_n` is low, `almost_empty_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_en1_n | input | 1 | Write enable, active low |
| wr_en2_ld | input | 1 | Second write enable or load-select; role latched during reset |
| din | input | 9 | Write data |
| rd_en1_n | input | 1 | Read enable one, active low |
| rd_en2_n | input | 1 | Read enable two, active low |
| ae_level | input | AW | Almost-empty threshold n |
| af_level | input | AW | Almost-full threshold m |
| out_en_n | input | 1 | Output drive request, active low |
| dout | output | 9 | Read data register |
| dout_drive | output | 1 | High when the output pads should drive |
| ofs_sel | output | 1 | Accesses are steered to the offset registers |
| empty_n | output | 1 | Empty flag, active low, read clock |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read clock |
| full_n | output | 1 | Full flag, active low, write clock |
| almost_full_n | output | 1 | Almost-full flag, active low, write clock |

## Verification
A write and a read can land in the same short window: a write edge and a read edge a few nanoseconds apart. The read side then consumes a pointer that the write side has just advanced. The bench provokes this by running the two 100 MHz clocks 2 ns out of phase. It holds both enables active while 40 words stream through an initially empty buffer. Each word on `dout` is judged against the write order, and the first word is checked on the read edge right after `empty_n` rises.

// File: rtl/fifo_dc_pkg.sv
// Shared types and pointer-code helpers for the dual-clock flag FIFO.
// Assumes no pointer is wider than PTR_MAX bits (depth up to 8192).
package fifo_dc_pkg;
    localparam int PTR_MAX = 14;

    typedef enum logic {
        WR2_AS_ENABLE = 1'b0,
        WR2_AS_LOAD   = 1'b1
    } wr2_role_e;

    // Binary to reflected Gray code.
    function automatic logic [PTR_MAX-1:0] to_gray(input logic [PTR_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [PTR_MAX-1:0] from_gray(input logic [PTR_MAX-1:0] g);
        logic [PTR_MAX-1:0] b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/fifo_dc_sync.sv
// Multi-stage synchroniser for a Gray-coded pointer.
// Assumes the input changes at most one bit per source-clock edge.
module fifo_dc_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the foreign-domain value.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Let metastability settle through one more stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_dc_ram.sv
// Storage array: written on the write clock, read combinationally.
// Assumes the read side registers the output itself.
module fifo_dc_ram #(
    parameter int DW = 9,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;
    logic [DW-1:0] cells [WORDS];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_dc_wr_side.sv
// Write-clock domain: write pointer, full and almost-full flags, and the
// role of the second write pin. Assumes the read pointer arrives synchronised.
module fifo_dc_wr_side
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int PW    = 7
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          en1_n,
    input  logic          en2_ld,
    input  logic [AW-1:0] af_level,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          we,
    output logic          full_n,
    output logic          af_n,
    output logic          ofs_sel,
    output wr2_role_e     role
);
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] words_nxt;
    logic [PW-1:0] af_thr;

    // Accept a data write only with enable 1 active, pin 2 high and room left.
    assign we        = !en1_n && en2_ld && full_n;
    assign wbin_nxt  = wbin + PW'(we);
    assign rbin_s    = PW'(from_gray(PTR_MAX'(rgray_s)));
    assign words_nxt = wbin_nxt - rbin_s;
    assign af_thr    = PW'(DEPTH) - {1'b0, af_level};
    assign ofs_sel   = (role == WR2_AS_LOAD) && !en2_ld;

    // Latch the pin role during reset; advance pointer and flags otherwise.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            role   <= en2_ld ? WR2_AS_ENABLE : WR2_AS_LOAD;
            wbin   <= '0;
            wgray  <= '0;
            full_n <= 1'b1;
            af_n   <= 1'b1;
        end else begin
            wbin   <= wbin_nxt;
            wgray  <= PW'(to_gray(PTR_MAX'(wbin_nxt)));
            full_n <= (words_nxt != PW'(DEPTH));
            af_n   <= (words_nxt < af_thr);
        end
    end
endmodule

// File: rtl/fifo_dc_rd_side.sv
// Read-clock domain: read pointer, output register, empty and almost-empty.
// Assumes the write pointer arrives synchronised and the load pin is stable
// around read edges while it is used.
module fifo_dc_rd_side
    import fifo_dc_pkg::*;
#(
    parameter int AW = 6,
    parameter int PW = 7,
    parameter int DW = 9
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          en1_n,
    input  logic          en2_n,
    input  logic          ld_pin,
    input  logic [AW-1:0] ae_level,
    input  logic [PW-1:0] wgray_s,
    input  logic [DW-1:0] rdata,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          ae_n
);
    wr2_role_e     role;
    logic          re;
    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] words_nxt;

    // Read only with both enables active, data present and no offset access.
    assign re        = !en1_n && !en2_n && empty_n &&
                       !((role == WR2_AS_LOAD) && !ld_pin);
    assign rbin_nxt  = rbin + PW'(re);
    assign wbin_s    = PW'(from_gray(PTR_MAX'(wgray_s)));
    assign words_nxt = wbin_s - rbin_nxt;
    assign raddr     = rbin[AW-1:0];

    // Latch the pin role during reset; advance pointer, data and flags otherwise.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            role    <= ld_pin ? WR2_AS_ENABLE : WR2_AS_LOAD;
            rbin    <= '0;
            rgray   <= '0;
            dout    <= '0;
            empty_n <= 1'b0;
            ae_n    <= 1'b0;
        end else begin
            rbin    <= rbin_nxt;
            rgray   <= PW'(to_gray(PTR_MAX'(rbin_nxt)));
            if (re) dout <= rdata;
            empty_n <= (words_nxt != '0);
            ae_n    <= (words_nxt > {1'b0, ae_level});
        end
    end
endmodule

// File: rtl/dual_clk_flag_fifo.sv
// Top: dual-clock 9-bit FIFO with runtime almost thresholds.
// Assumes DEPTH is a power of two from 64 to 8192 and that rst_n is held low
// for at least two edges of each clock.
module dual_clk_flag_fifo
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int DW          = 9,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_en1_n,
    input  logic          wr_en2_ld,
    input  logic [DW-1:0] din,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic [AW-1:0] ae_level,
    input  logic [AW-1:0] af_level,
    input  logic          out_en_n,
    output logic [DW-1:0] dout,
    output logic          dout_drive,
    output logic          ofs_sel,
    output logic          empty_n,
    output logic          almost_empty_n,
    output logic          full_n,
    output logic          almost_full_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_ptr_bin, wr_ptr_gray, wr_ptr_gray_s;
    logic [PW-1:0] rd_ptr_bin, rd_ptr_gray, rd_ptr_gray_s;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          wr_accept;
    wr2_role_e     wr_role;

    assign dout_drive = !out_en_n;

    fifo_dc_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wclk    (wclk),
        .rst_n   (rst_n),
        .en1_n   (wr_en1_n),
        .en2_ld  (wr_en2_ld),
        .af_level(af_level),
        .rgray_s (rd_ptr_gray_s),
        .wbin    (wr_ptr_bin),
        .wgray   (wr_ptr_gray),
        .we      (wr_accept),
        .full_n  (full_n),
        .af_n    (almost_full_n),
        .ofs_sel (ofs_sel),
        .role    (wr_role)
    );

    fifo_dc_rd_side #(.AW(AW), .PW(PW), .DW(DW)) u_rd (
        .rclk    (rclk),
        .rst_n   (rst_n),
        .en1_n   (rd_en1_n),
        .en2_n   (rd_en2_n),
        .ld_pin  (wr_en2_ld),
        .ae_level(ae_level),
        .wgray_s (wr_ptr_gray_s),
        .rdata   (rd_data),
        .rbin    (rd_ptr_bin),
        .rgray   (rd_ptr_gray),
        .raddr   (rd_addr),
        .dout    (dout),
        .empty_n (empty_n),
        .ae_n    (almost_empty_n)
    );

    fifo_dc_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk (wclk),
        .we   (wr_accept),
        .waddr(wr_ptr_bin[AW-1:0]),
        .wdata(din),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    fifo_dc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk  (rclk),
        .rst_n(rst_n),
        .d    (wr_ptr_gray),
        .q    (wr_ptr_gray_s)
    );

    fifo_dc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk  (wclk),
        .rst_n(rst_n),
        .d    (rd_ptr_gray),
        .q    (rd_ptr_gray_s)
    );
endmodule

// File: rtl/fifo_dc_chk.sv
// Property checker for the dual-clock FIFO, attached by bind.
module fifo_dc_chk #(
    parameter int PW = 7,
    parameter int DW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          full_n,
    input logic          af_n,
    input logic          empty_n,
    input logic          ae_n,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic [DW-1:0] dout,
    input logic          role_w
);
    // R5
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wr_ptr));

    // R6
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> ($stable(rd_ptr) && $stable(dout)));

    // R12
    full_has_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !af_n);

    // R12
    empty_has_ae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !ae_n);

    // R9
    wr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> ((wr_ptr - $past(wr_ptr)) <= PW'(1)));

    // R9
    rd_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        1'b1 |=> ((rd_ptr - $past(rd_ptr)) <= PW'(1)));

    // R2
    role_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> $stable(role_w));
endmodule

bind dual_clk_flag_fifo fifo_dc_chk #(.PW(PW), .DW(DW)) u_chk (
    .wclk   (wclk),
    .rclk   (rclk),
    .rst_n  (rst_n),
    .full_n (full_n),
    .af_n   (almost_full_n),
    .empty_n(empty_n),
    .ae_n   (almost_empty_n),
    .wr_ptr (wr_ptr_bin),
    .rd_ptr (rd_ptr_bin),
    .dout   (dout),
    .role_w (wr_role)
);

// File: tb/dual_clk_flag_fifo_test.sv
module dual_clk_flag_fifo_test;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic wr_en1_n = 1'b1, wr_en2_ld = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic out_en_n = 1'b1;
    logic [8:0] din = '0;
    logic [AW-1:0] ae_level = 6'd7, af_level = 6'd7;
    logic [8:0] dout;
    logic dout_drive, ofs_sel, empty_n, almost_empty_n, full_n, almost_full_n;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // {expected almost_empty_n after this write settles, data word}
    localparam logic [9:0] WVEC [8] = '{
        {1'b0, 9'h1A5}, {1'b0, 9'h05A}, {1'b0, 9'h100}, {1'b0, 9'h0FF},
        {1'b0, 9'h001}, {1'b0, 9'h1FE}, {1'b0, 9'h0C3}, {1'b1, 9'h13C}
    };

    dual_clk_flag_fifo #(.DEPTH(DEPTH)) uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld), .din(din),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
        .ae_level(ae_level), .af_level(af_level), .out_en_n(out_en_n),
        .dout(dout), .dout_drive(dout_drive), .ofs_sel(ofs_sel),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n),
        .full_n(full_n), .almost_full_n(almost_full_n)
    );

    always #5 wclk = ~wclk;
    initial begin
        #2;
        forever #5 rclk = ~rclk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wsettle(input int n);
        repeat (n) @(negedge wclk);
    endtask

    task automatic rsettle(input int n);
        repeat (n) @(negedge rclk);
    endtask

    task automatic wr_word(input logic [8:0] d);
        @(negedge wclk);
        wr_en1_n = 1'b0; wr_en2_ld = 1'b1; din = d;
        @(negedge wclk);
        wr_en1_n = 1'b1;
    endtask

    task automatic rd_word();
        @(negedge rclk);
        rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge rclk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    endtask

    task automatic do_reset(input logic role_pin);
        @(negedge wclk);
        rst_n = 1'b0; wr_en2_ld = role_pin;
        wr_en1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        wsettle(4);
        rst_n = 1'b1;
        wsettle(2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // ---------------- two-enable mode ----------------
        do_reset(1'b1);
        chk("R1 empty_n", empty_n, 0);
        chk("R1 almost_empty_n", almost_empty_n, 0);
        chk("R1 full_n", full_n, 1);
        chk("R1 almost_full_n", almost_full_n, 1);
        chk("R1 dout", dout, 0);
        chk("R3 ofs_sel two-enable", ofs_sel, 0);
        chk("R11 drive off", dout_drive, 0);
        out_en_n = 1'b0; #1;
        chk("R11 drive on", dout_drive, 1);

        // Table walk: write vectors, judge almost-empty after each (n=7)
        for (int i = 0; i < 8; i++) begin
            wr_word(WVEC[i][8:0]);
            rsettle(6);
            chk("R7 almost_empty_n", almost_empty_n, int'(WVEC[i][9]));
            chk("R10 empty released", empty_n, 1);
        end

        // R2: second enable low refuses the write
        @(negedge wclk);
        wr_en1_n = 1'b0; wr_en2_ld = 1'b0; din = 9'h0AA;
        @(negedge wclk);
        wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
        chk("R3 ofs_sel stays low", ofs_sel, 0);
        rsettle(6);

        // R4: one read enable alone does nothing
        @(negedge rclk);
        rd_en1_n = 1'b0; rd_en2_n = 1'b1;
        @(negedge rclk);
        rd_en1_n = 1'b1;
        chk("R4 single enable dout", dout, 0);

        for (int i = 0; i < 8; i++) begin
            rd_word();
            chk("R4 read data", dout, int'(WVEC[i][8:0]));
        end
        chk("R6 empty after last", empty_n, 0);
        chk("R2 refused word absent", empty_n, 0);

        // R6: read while empty keeps last word
        rd_word();
        chk("R6 dout held", dout, int'(WVEC[7][8:0]));
        chk("R6 still empty", empty_n, 0);
        wsettle(6);

        // R5/R8: fill to full, m=7 -> almost-full at 57 words
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(9'(i * 3 + 5));
            if (i + 1 == 56) chk("R8 af high at 56", almost_full_n, 1);
            if (i + 1 == 57) chk("R8 af low at 57", almost_full_n, 0);
            if (i + 1 == 63) chk("R5 not full at 63", full_n, 1);
            if (i + 1 == 64) chk("R5 full at 64", full_n, 0);
        end
        wr_word(9'h1FF);
        chk("R5 full holds", full_n, 0);
        rsettle(6);
        for (int i = 0; i < DEPTH; i++) begin
            rd_word();
            chk("R5 fill order", dout, (i * 3 + 5) & 9'h1FF);
        end
        chk("R5 overflow word absent", empty_n, 0);
        wsettle(6);
        chk("R10 full released", full_n, 1);
        chk("R8 af released", almost_full_n, 1);

        // R9: simultaneous streaming from empty
        fork
            begin
                for (int k = 0; k < 40; k++) begin
                    @(negedge wclk);
                    wr_en1_n = 1'b0; wr_en2_ld = 1'b1; din = 9'(k * 7 + 3);
                end
                @(negedge wclk);
                wr_en1_n = 1'b1;
            end
            begin
                int got = 0;
                bit pend = 1'b0;
                @(negedge rclk);
                rd_en1_n = 1'b0; rd_en2_n = 1'b0;
                for (int t = 0; t < 2000 && got < 40; t++) begin
                    @(negedge rclk);
                    if (pend) begin
                        chk("R9 stream order", dout, (got * 7 + 3) & 9'h1FF);
                        got++;
                    end
                    pend = empty_n;
                end
                rd_en1_n = 1'b1; rd_en2_n = 1'b1;
                chk("R9 stream count", got, 40);
            end
        join
        rsettle(6);
        chk("R9 empty after stream", empty_n, 0);

        // ---------------- load-select mode ----------------
        do_reset(1'b0);
        chk("R1 dout after second reset", dout, 0);
        chk("R3 ofs_sel with load low", ofs_sel, 1);
        wr_word(9'h011);
        chk("R3 ofs_sel with load high", ofs_sel, 0);
        wr_word(9'h022);
        wr_word(9'h033);
        // Load low: write goes to offset block, not data memory
        @(negedge wclk);
        wr_en1_n = 1'b0; wr_en2_ld = 1'b0; din = 9'h0EE;
        @(negedge wclk);
        wr_en1_n = 1'b1;
        ae_level = 6'd2;
        rsettle(6);
        chk("R7 ae high above n=2", almost_empty_n, 1);
        ae_level = 6'd3;
        rsettle(3);
        chk("R7 ae low at n=3", almost_empty_n, 0);
        // Load low: read refused
        rd_word();
        chk("R3 read refused dout", dout, 0);
        chk("R3 read refused empty", empty_n, 1);
        wr_en2_ld = 1'b1;
        rd_word();
        chk("R3 data word 1", dout, 9'h011);
        rd_word();
        chk("R3 data word 2", dout, 9'h022);
        rd_word();
        chk("R3 data word 3", dout, 9'h033);
        chk("R3 offset write absent", empty_n, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule